// File: doc/BRIEF.md
# Channel Link and Completion Controller

This block is the per-channel control and status logic placed around a single shared transfer engine that serves several channels (eight by default). It keeps one enable bit, one pending bit, one done flag, one interrupt flag and one error flag per channel. Software drives it through a command port that carries an operation code and a channel number. Peripherals drive it through per-channel request lines. From the pending set it picks the lowest-numbered channel and starts the engine on it. The engine then reports each finished minor loop, with a flag that marks the final minor loop of the major loop.

On each minor loop completion the block reads the active channel's control word and iteration word from the descriptor configuration inputs. From these it may start a linked channel after any minor loop except the last, or start a linked channel once at major completion. It may also clear the channel's enable, raise an interrupt, set the done flag, insert bandwidth stall cycles, or reload the channel's eight-word descriptor from memory (scatter-gather). The memory read port has one cycle of latency. Reloaded words go to the descriptor store through a plain write port.

Top module: `chlink_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every enable, done, interrupt and error flag is 0, `eng_start` is 0 and no memory read is issued.
- R2: A command is taken when `cmd_valid` is 1, acting on channel `cmd_chan`. The `cmd_op` codes are 0 set enable, 1 clear enable, 2 software start, 3 clear done, 4 clear interrupt, 5 clear error. Set and clear enable show on `en_flags` one cycle later.
- R3: A pulse on `hw_req[i]` makes channel i pending only while enable bit i is set. Otherwise the pulse is ignored and no start follows.
- R4: Among pending channels the lowest number is served first. `eng_start` is a one-cycle pulse two cycles after the request, with `eng_chan` holding the channel until the engine reports completion.
- R5: A trigger for a channel that arrives while the engine is busy stays pending and is served after the current minor loop.
- R6: Iteration word bit 15 enables minor linking to the channel in bits 9 upward. A non-final minor completion makes that channel pending; a final completion does not.
- R7: Control word bit 5 enables major linking to the channel in bits 8 upward. A final completion makes that channel pending exactly once.
- R8: Control word bit 3 set clears the channel's enable at final completion. If bit 3 is clear, the channel stays enabled.
- R9: Control word bit 1 set raises `irq[ch]` at final completion. The clear-interrupt command drops it.
- R10: Final completion without scatter-gather sets `done_flags[ch]`. The clear-done command clears it.
- R11: Control word bit 4 makes final completion read eight words from `cfg_sga[ch]`, an address aligned to 32 bytes, at byte offsets 0,4,...,28 in order. Each word is written to descriptor index 0..7 of the channel. The done flag stays clear, and no channel starts until the reload ends.
- R12: Control word bits 15:14 equal to 2 insert 4 idle cycles after each minor loop before the next start. A value of 3 inserts 8 idle cycles. Values 0 and 1 insert none.
- R13: A pulse on `err_set[i]` sets `err_flags[i]`. The clear-error command clears it.
- R14: A channel may link to itself. It is re-queued and restarted after its own minor loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command operation code |
| cmd_chan | input | CW | Channel the command acts on |
| hw_req | input | NCH | Per-channel hardware request pulses |
| err_set | input | NCH | Per-channel error report pulses |
| cfg_csr | input | NCH x 16 | Per-channel control word |
| cfg_iter | input | NCH x 16 | Per-channel iteration word (link fields) |
| cfg_sga | input | NCH x AW | Per-channel reload descriptor address |
| eng_start | output | 1 | Start pulse to the engine |
| eng_chan | output | CW | Channel the engine serves |
| eng_done | input | 1 | Engine finished a minor loop |
| eng_last | input | 1 | That minor loop was the final one |
| en_flags | output | NCH | Enable bits |
| done_flags | output | NCH | Done flags |
| irq | output | NCH | Interrupt flags |
| err_flags | output | NCH | Error flags |
| mem_rd_en | output | 1 | Descriptor memory read strobe |
| mem_rd_addr | output | AW | Descriptor memory byte address |
| mem_rd_data | input | DW | Read data, one cycle after the strobe |
| desc_wr_en | output | 1 | Descriptor store write strobe |
| desc_wr_chan | output | CW | Channel being reloaded |
| desc_wr_idx | output | 3 | Descriptor word index |
| desc_wr_data | output | DW | Descriptor word |

## Verification
The bench checks that a final minor loop does not fire the minor link. A design that checked only the link enable would restart the target once too often. It also checks that a trigger for the busy channel is held pending, since a design that dropped it would never restart that channel. It counts the exact idle cycles inserted by both stall settings, because an off-by-one timer would start the next channel a cycle early or late. Finally, it checks that the reload reads all eight words in address order, leaves done clear, and holds off a waiting channel until the last write.

// File: rtl/chlink_pkg.sv
// Shared encodings for the channel link and completion controller.
// Assumes control and iteration words are 16 bits wide.
package chlink_pkg;
    typedef enum logic [2:0] {
        OP_SET_EN   = 3'd0,
        OP_CLR_EN   = 3'd1,
        OP_SW_START = 3'd2,
        OP_CLR_DONE = 3'd3,
        OP_CLR_INT  = 3'd4,
        OP_CLR_ERR  = 3'd5
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_STALL = 2'd2,
        ST_FETCH = 2'd3
    } ctl_state_e;

    // control word fields
    localparam int CSR_INT_MAJ  = 1;
    localparam int CSR_DIS_DONE = 3;
    localparam int CSR_SG_EN    = 4;
    localparam int CSR_MLINK_EN = 5;
    localparam int CSR_MLINK_CH = 8;
    localparam int CSR_BW_LO    = 14;
    // iteration word fields
    localparam int ITER_LINK_EN = 15;
    localparam int ITER_LINK_CH = 9;
    // descriptor and stall sizing
    localparam int DESC_WORDS      = 8;
    localparam int STALL_W         = 4;
    localparam int BW_STALL_SHORT  = 4;
    localparam int BW_STALL_LONG   = 8;
endpackage

// File: rtl/chlink_pick.sv
// Fixed-priority picker: reports whether any request is set and the
// lowest set index. Purely combinational; assumes N <= 2**W.
module chlink_pick #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    // scan from the top so the lowest set bit is the last written
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/chlink_stall.sv
// Bandwidth stall timer: loaded with a length, counts down to zero.
// 'last' is high in the final stall cycle. A load of zero does nothing.
module chlink_stall #(
    parameter int CNTW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CNTW-1:0] len,
    output logic            last
);
    logic [CNTW-1:0] cnt_q;

    // count down the remaining idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= len;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == CNTW'(1));
endmodule

// File: rtl/chlink_sg_fetch.sv
// Scatter-gather reloader: after 'start', reads WORDS consecutive words
// from 'base' (byte address, word step 4) and forwards each one as a
// write one cycle later, when memory data returns. Assumes a read
// latency of exactly one cycle.
module chlink_sg_fetch #(
    parameter int AW    = 32,
    parameter int WORDS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [AW-1:0]            base,
    output logic                     rd_en,
    output logic [AW-1:0]            rd_addr,
    output logic                     wr_en,
    output logic [$clog2(WORDS)-1:0] wr_idx,
    output logic                     finish
);
    localparam int IW = $clog2(WORDS);

    logic          active_q;
    logic [IW:0]   rd_cnt_q;
    logic [AW-1:0] base_q;
    logic          wr_en_q;
    logic [IW-1:0] wr_idx_q;

    assign rd_en   = active_q && (rd_cnt_q < (IW + 1)'(WORDS));
    assign rd_addr = base_q + AW'({rd_cnt_q, 2'b00});
    assign wr_en   = wr_en_q;
    assign wr_idx  = wr_idx_q;
    assign finish  = wr_en_q && (wr_idx_q == IW'(WORDS - 1));

    // read sequencing and write alignment to the returning data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            rd_cnt_q <= '0;
            base_q   <= '0;
            wr_en_q  <= 1'b0;
            wr_idx_q <= '0;
        end else begin
            wr_en_q  <= rd_en;
            wr_idx_q <= rd_cnt_q[IW-1:0];
            if (start) begin
                active_q <= 1'b1;
                rd_cnt_q <= '0;
                base_q   <= base;
            end else begin
                if (rd_en)  rd_cnt_q <= rd_cnt_q + 1'b1;
                if (finish) active_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/chlink_ctrl.sv
// Channel link and completion controller. Holds the per-channel enable,
// pending, done, interrupt and error bits, and serves pending channels
// one minor loop at a time on a shared engine (lowest number first).
// On each minor completion it applies the active channel's link,
// disable, interrupt, done, bandwidth-stall and scatter-gather
// settings. Assumes eng_done is only pulsed while a channel is active.
module chlink_ctrl
    import chlink_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 32,
    parameter int DW  = 32,
    localparam int CW = $clog2(NCH),
    localparam int IW = $clog2(DESC_WORDS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_op,
    input  logic [CW-1:0]           cmd_chan,
    input  logic [NCH-1:0]          hw_req,
    input  logic [NCH-1:0]          err_set,
    input  logic [NCH-1:0][15:0]    cfg_csr,
    input  logic [NCH-1:0][15:0]    cfg_iter,
    input  logic [NCH-1:0][AW-1:0]  cfg_sga,
    output logic                    eng_start,
    output logic [CW-1:0]           eng_chan,
    input  logic                    eng_done,
    input  logic                    eng_last,
    output logic [NCH-1:0]          en_flags,
    output logic [NCH-1:0]          done_flags,
    output logic [NCH-1:0]          irq,
    output logic [NCH-1:0]          err_flags,
    output logic                    mem_rd_en,
    output logic [AW-1:0]           mem_rd_addr,
    input  logic [DW-1:0]           mem_rd_data,
    output logic                    desc_wr_en,
    output logic [CW-1:0]           desc_wr_chan,
    output logic [IW-1:0]           desc_wr_idx,
    output logic [DW-1:0]           desc_wr_data
);
    function automatic logic [NCH-1:0] ch_bit(input logic [CW-1:0] c);
        ch_bit = NCH'(1) << c;
    endfunction

    ctl_state_e     state_q, state_d;
    logic [CW-1:0]  act_q;
    logic           start_q;
    logic [NCH-1:0] en_q, pend_q, done_q, int_q, err_q;

    cmd_op_e        op;
    logic [NCH-1:0] set_en_v, clr_en_v, sw_go_v, clr_done_v, clr_int_v, clr_err_v;
    logic [NCH-1:0] link_v, grant_v, dis_v, done_v, int_v;
    logic           pick_any;
    logic [CW-1:0]  pick_idx;
    logic           fin, fin_last, fin_minor;
    logic [15:0]    csr_a, iter_a;
    logic           sg_en, sg_start, sg_finish;
    logic           stall_load, stall_last;
    logic [STALL_W-1:0] stall_len;
    logic           unused_cfg;

    assign op         = cmd_op_e'(cmd_op);
    assign set_en_v   = (cmd_valid && op == OP_SET_EN)   ? ch_bit(cmd_chan) : '0;
    assign clr_en_v   = (cmd_valid && op == OP_CLR_EN)   ? ch_bit(cmd_chan) : '0;
    assign sw_go_v    = (cmd_valid && op == OP_SW_START) ? ch_bit(cmd_chan) : '0;
    assign clr_done_v = (cmd_valid && op == OP_CLR_DONE) ? ch_bit(cmd_chan) : '0;
    assign clr_int_v  = (cmd_valid && op == OP_CLR_INT)  ? ch_bit(cmd_chan) : '0;
    assign clr_err_v  = (cmd_valid && op == OP_CLR_ERR)  ? ch_bit(cmd_chan) : '0;

    assign csr_a      = cfg_csr[act_q];
    assign iter_a     = cfg_iter[act_q];
    assign unused_cfg = ^{csr_a, iter_a};
    assign fin        = (state_q == ST_BUSY) && eng_done;
    assign fin_last   = fin && eng_last;
    assign fin_minor  = fin && !eng_last;
    assign sg_en      = csr_a[CSR_SG_EN];
    assign sg_start   = fin_last && sg_en;

    chlink_pick #(.N(NCH), .W(CW)) u_pick (
        .req(pend_q), .any(pick_any), .idx(pick_idx)
    );

    // bandwidth field decode into idle cycle count
    always_comb begin
        case (csr_a[CSR_BW_LO +: 2])
            2'b10:   stall_len = STALL_W'(BW_STALL_SHORT);
            2'b11:   stall_len = STALL_W'(BW_STALL_LONG);
            default: stall_len = '0;
        endcase
    end
    assign stall_load = fin && !sg_start && (stall_len != '0);

    chlink_stall #(.CNTW(STALL_W)) u_stall (
        .clk(clk), .rst_n(rst_n), .load(stall_load), .len(stall_len), .last(stall_last)
    );

    chlink_sg_fetch #(.AW(AW), .WORDS(DESC_WORDS)) u_sg (
        .clk(clk), .rst_n(rst_n), .start(sg_start), .base(cfg_sga[act_q]),
        .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .wr_en(desc_wr_en),
        .wr_idx(desc_wr_idx), .finish(sg_finish)
    );
    assign desc_wr_data = mem_rd_data;
    assign desc_wr_chan = act_q;

    // completion side effects on the active channel
    always_comb begin
        link_v = '0;
        if (fin_minor && iter_a[ITER_LINK_EN]) link_v |= ch_bit(iter_a[ITER_LINK_CH +: CW]);
        if (fin_last && csr_a[CSR_MLINK_EN])   link_v |= ch_bit(csr_a[CSR_MLINK_CH +: CW]);
        dis_v  = (fin_last && csr_a[CSR_DIS_DONE]) ? ch_bit(act_q) : '0;
        done_v = (fin_last && !sg_en)              ? ch_bit(act_q) : '0;
        int_v  = (fin_last && csr_a[CSR_INT_MAJ])  ? ch_bit(act_q) : '0;
    end

    assign grant_v = (state_q == ST_IDLE && pick_any) ? ch_bit(pick_idx) : '0;

    // controller sequencing
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (pick_any) state_d = ST_BUSY;
            ST_BUSY:  if (fin) state_d = sg_start ? ST_FETCH : (stall_load ? ST_STALL : ST_IDLE);
            ST_STALL: if (stall_last) state_d = ST_IDLE;
            ST_FETCH: if (sg_finish) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state, grant and per-channel flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_q   <= '0;
            start_q <= 1'b0;
            en_q    <= '0;
            pend_q  <= '0;
            done_q  <= '0;
            int_q   <= '0;
            err_q   <= '0;
        end else begin
            state_q <= state_d;
            start_q <= (state_q == ST_IDLE) && pick_any;
            if (state_q == ST_IDLE && pick_any) act_q <= pick_idx;
            en_q   <= (en_q | set_en_v) & ~clr_en_v & ~dis_v;
            pend_q <= (pend_q & ~grant_v) | (hw_req & en_q) | sw_go_v | link_v;
            done_q <= (done_q & ~clr_done_v) | done_v;
            int_q  <= (int_q & ~clr_int_v) | int_v;
            err_q  <= (err_q & ~clr_err_v) | err_set;
        end
    end

    assign eng_start  = start_q;
    assign eng_chan   = act_q;
    assign en_flags   = en_q;
    assign done_flags = done_q;
    assign irq        = int_q;
    assign err_flags  = err_q;

    // R5
    busy_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && !eng_done) |=> !eng_start);
    // R12
    stall_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL) |=> !eng_start);
    // R11
    fetch_only_in_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (state_q == ST_FETCH));
    // R11
    reload_addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sg_start |-> (cfg_sga[act_q][4:0] == 5'd0));
    // R8
    disable_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_last && csr_a[CSR_DIS_DONE]) |=> !en_flags[$past(act_q)]);
    // R10
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_last && !sg_en) |=> done_flags[$past(act_q)]);
endmodule

// File: tb/chlink_ctrl_tb_top.sv
`timescale 1ns/1ps
module chlink_ctrl_tb_top;
    localparam int NCH = 8;
    localparam int CW  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [CW-1:0] cmd_chan = '0;
    logic [NCH-1:0] hw_req = '0, err_set = '0;
    logic [NCH-1:0][15:0] cfg_csr, cfg_iter;
    logic [NCH-1:0][31:0] cfg_sga;
    logic eng_start, eng_done = 1'b0, eng_last = 1'b0;
    logic [CW-1:0] eng_chan;
    logic [NCH-1:0] en_flags, done_flags, irq, err_flags;
    logic mem_rd_en;
    logic [31:0] mem_rd_addr, mem_rd_data = '0;
    logic desc_wr_en;
    logic [CW-1:0] desc_wr_chan;
    logic [2:0] desc_wr_idx;
    logic [31:0] desc_wr_data;

    int checks = 0, fails = 0;
    int wr_cnt = 0, wr_bad = 0;
    logic [31:0] sg_base = 32'h0000_1A40;
    bit finished = 0;

    always #2 clk = ~clk;

    chlink_ctrl #(.NCH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_chan(cmd_chan), .hw_req(hw_req), .err_set(err_set),
        .cfg_csr(cfg_csr), .cfg_iter(cfg_iter), .cfg_sga(cfg_sga),
        .eng_start(eng_start), .eng_chan(eng_chan), .eng_done(eng_done),
        .eng_last(eng_last), .en_flags(en_flags), .done_flags(done_flags),
        .irq(irq), .err_flags(err_flags), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .desc_wr_en(desc_wr_en), .desc_wr_chan(desc_wr_chan),
        .desc_wr_idx(desc_wr_idx), .desc_wr_data(desc_wr_data)
    );

    // memory model: one-cycle read latency, content derived from address
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_rd_addr ^ 32'h5A5A_0000;

    // reload write monitor (R11)
    always @(negedge clk) begin
        if (rst_n && desc_wr_en) begin
            if (desc_wr_idx != wr_cnt[2:0] || desc_wr_chan != 3'd3 ||
                desc_wr_data != ((sg_base + 32'(wr_cnt * 4)) ^ 32'h5A5A_0000))
                wr_bad++;
            wr_cnt++;
        end
    end

    // vectors: {enable mask, request mask, start expected, first channel}
    localparam logic [19:0] VEC [0:5] = '{
        {8'hFF, 8'h0C, 1'b1, 3'd2},
        {8'hFF, 8'h81, 1'b1, 3'd0},
        {8'hF0, 8'h0F, 1'b0, 3'd0},
        {8'h80, 8'h80, 1'b1, 3'd7},
        {8'h0A, 8'h0F, 1'b1, 3'd1},
        {8'hFF, 8'h60, 1'b1, 3'd5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        cfg_csr = '0; cfg_iter = '0; cfg_sga = '0;
        hw_req = '0; err_set = '0; eng_done = 0; eng_last = 0; cmd_valid = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
    endtask

    task automatic cmd(input logic [2:0] op, input logic [CW-1:0] ch);
        cmd_valid = 1; cmd_op = op; cmd_chan = ch;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic pulse_req(input logic [NCH-1:0] m);
        hw_req = m;
        @(negedge clk);
        hw_req = '0;
    endtask

    task automatic finish_loop(input logic last);
        eng_done = 1; eng_last = last;
        @(negedge clk);
        eng_done = 0; eng_last = 0;
    endtask

    task automatic drain();
        for (int k = 0; k < 40; k++) begin
            if (eng_start) finish_loop(1'b1);
            else @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 flags", {en_flags, done_flags, irq, err_flags}, 32'h0);
        check("R1 start", {31'h0, eng_start}, 32'h0);
        check("R1 read", {31'h0, mem_rd_en}, 32'h0);

        // R4 / R3 priority table
        for (int v = 0; v < 6; v++) begin
            do_reset();
            for (int i = 0; i < NCH; i++) if (VEC[v][12 + i]) cmd(3'd0, CW'(i));
            pulse_req(VEC[v][11:4]);
            @(negedge clk);
            check("R4 R3 start", {31'h0, eng_start}, {31'h0, VEC[v][3]});
            if (VEC[v][3]) check("R4 chan", {29'h0, eng_chan}, {29'h0, VEC[v][2:0]});
            drain();
        end

        // R2 set and clear enable
        do_reset();
        cmd(3'd0, 3'd6);
        check("R2 set en", {24'h0, en_flags}, 32'h40);
        cmd(3'd1, 3'd6);
        check("R2 clr en", {24'h0, en_flags}, 32'h0);

        // R5 pending while busy, R10 done, R8 stays enabled
        do_reset();
        cmd(3'd0, 3'd3); cmd(3'd0, 3'd1);
        pulse_req(8'h08);
        @(negedge clk);
        check("R5 first", {28'h0, eng_start, eng_chan}, {28'h0, 1'b1, 3'd3});
        pulse_req(8'h02);
        for (int k = 0; k < 3; k++) check("R5 held", {31'h0, eng_start}, 32'h0);
        repeat (3) @(negedge clk);
        finish_loop(1'b1);
        check("R10 done set", {24'h0, done_flags}, 32'h08);
        check("R8 stays en", {24'h0, en_flags}, 32'h0A);
        @(negedge clk);
        check("R5 served", {28'h0, eng_start, eng_chan}, {28'h0, 1'b1, 3'd1});
        finish_loop(1'b1);
        cmd(3'd3, 3'd3);
        check("R10 clr done", {24'h0, done_flags}, 32'h02);

        // R6 minor link, R2 software start
        do_reset();
        cfg_iter[2] = 16'h8000 | (16'd5 << 9);
        cmd(3'd2, 3'd2);
        @(negedge clk);
        check("R2 sw start", {28'h0, eng_start, eng_chan}, {28'h0, 1'b1, 3'd2});
        finish_loop(1'b0);
        @(negedge clk);
        check("R6 minor link", {28'h0, eng_start, eng_chan}, {28'h0, 1'b1, 3'd5});
        finish_loop(1'b1);
        cmd(3'd2, 3'd2);
        @(negedge clk);
        finish_loop(1'b1);
        @(negedge clk);
        check("R6 no link on last", {31'h0, eng_start}, 32'h0);
        @(negedge clk);
        check("R6 no link on last", {31'h0, eng_start}, 32'h0);

        // R7 major link, R8 disable, R9 interrupt, R3 ignored after disable
        do_reset();
        cfg_csr[4] = (16'd6 << 8) | 16'h0020 | 16'h0008 | 16'h0002;
        cmd(3'd0, 3'd4);
        pulse_req(8'h10);
        @(negedge clk);
        finish_loop(1'b1);
        check("R8 disabled", {24'h0, en_flags}, 32'h0);
        check("R9 irq", {24'h0, irq}, 32'h10);
        @(negedge clk);
        check("R7 major link", {28'h0, eng_start, eng_chan}, {28'h0, 1'b1, 3'd6});
        finish_loop(1'b1);
        check("R10 linked done", {24'h0, done_flags}, 32'h50);
        cmd(3'd4, 3'd4);
        check("R9 clr irq", {24'h0, irq}, 32'h0);
        pulse_req(8'h10);
        @(negedge clk);
        check("R3 ignored", {31'h0, eng_start}, 32'h0);
        @(negedge clk);
        check("R7 once", {31'h0, eng_start}, 32'h0);

        // R14 self link
        do_reset();
        cfg_iter[0] = 16'h8000;
        cmd(3'd2, 3'd0);
        @(negedge clk);
        finish_loop(1'b0);
        @(negedge clk);
        check("R14 self", {28'h0, eng_start, eng_chan}, {28'h0, 1'b1, 3'd0});
        finish_loop(1'b1);
        @(negedge clk);
        check("R14 stops", {31'h0, eng_start}, 32'h0);

        // R12 bandwidth stall, both settings
        for (int s = 0; s < 2; s++) begin
            do_reset();
            cfg_csr[1] = (s == 0) ? 16'h8000 : 16'hC000;
            cfg_iter[1] = 16'h8000 | (16'd1 << 9);
            cmd(3'd2, 3'd1);
            @(negedge clk);
            finish_loop(1'b0);
            for (int k = 0; k < ((s == 0) ? 5 : 9); k++) begin
                check("R12 idle", {31'h0, eng_start}, 32'h0);
                @(negedge clk);
            end
            check("R12 restart", {31'h0, eng_start}, 32'h1);
        end

        // R11 scatter-gather reload
        do_reset();
        wr_cnt = 0; wr_bad = 0;
        cfg_csr[3] = 16'h0010;
        cfg_sga[3] = sg_base;
        cmd(3'd0, 3'd5);
        cmd(3'd2, 3'd3);
        @(negedge clk);
        finish_loop(1'b1);
        pulse_req(8'h20);
        for (int k = 0; k < 9; k++) begin
            check("R11 hold off", {31'h0, eng_start}, 32'h0);
            @(negedge clk);
        end
        check("R11 resume", {28'h0, eng_start, eng_chan}, {28'h0, 1'b1, 3'd5});
        check("R11 words", wr_cnt, 32'd8);
        check("R11 data", wr_bad, 32'd0);
        check("R11 done clear", {31'h0, done_flags[3]}, 32'h0);

        // R13 error flags
        do_reset();
        err_set = 8'h12;
        @(negedge clk);
        err_set = '0;
        check("R13 set", {24'h0, err_flags}, 32'h12);
        cmd(3'd5, 3'd4);
        check("R13 clear", {24'h0, err_flags}, 32'h02);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule